// File: doc/BRIEF.md
# Clock Throttle Timer with Break Events

This block produces an active-low stop request for a processor clock and toggles it on its own while throttling is switched on. The output spends a programmable number of slow ticks in the running phase (output high), then a second programmable number of ticks in the stopped phase (output low), and repeats. The ticks arrive on a one-cycle pulse input that fires once every 32 us, so each 8-bit count spans roughly 32 us to 8 ms.

A set of interrupt request lines can cut the stopped phase short. Each line passes through a synchronizer and is edge-detected. When a line whose enable bit is set rises, the output returns high at once and the running-phase timer restarts from its full count. A break that arrives while the output is already high only restarts the timer. Line 2 is reserved and can never act as a break. A zero count is illegal. The block runs it as a count of one and raises a sticky error flag.

Software reaches four byte-wide registers through a simple write strobe and a combinational read port.

Top module: `throttle_timer`

## Requirements
- R1: After reset `cpu_stop_n` is high, `cnt_err` is low, and all four registers read 00h.
- R2: The register map is: address 0 control (bit 1 = throttle enable, other bits read 0), address 1 running-phase count, address 2 stopped-phase count, address 3 break mask (bit n enables line n). Written values read back unchanged, except that mask bit 2 always reads 0.
- R3: While the enable bit is clear, `cpu_stop_n` stays high and ticks and interrupt edges have no effect. Clearing the enable bit while the output is low drives it high by the second clock edge after the write.
- R4: Once enabled, and after every return to high, the output stays high for exactly the running-phase count of ticks. It falls on the clock edge that samples the last of those ticks.
- R5: The stopped phase lasts exactly the stopped-phase count of ticks, and the output then rises on the edge that samples the last tick.
- R6: A rising edge on an enabled line while the output is low drives `cpu_stop_n` high on the third clock edge after the line rises. The next running phase then lasts the full running-phase count.
- R7: A rising edge on an enabled line while the output is high reloads the running-phase timer, so the full running-phase count of ticks must pass again before the output falls.
- R8: An edge on line 2, or on any line whose mask bit is 0, leaves the output and the phase timing unchanged.
- R9: Only a rising edge counts as a break. A line held high gives one break and does not shorten later stopped phases.
- R10: A count of 00h acts as a count of one tick. Loading a zero count sets `cnt_err`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 32 us |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| irq | input | 8 | Interrupt request lines, asynchronous |
| cpu_stop_n | output | 1 | Active-low clock stop request |
| cnt_err | output | 1 | Sticky flag for a loaded zero count |

## Verification
A register write takes effect at the edge that samples it. The timer first acts on a new enable bit one edge later, so the bench waits two cycles after enabling before it gives any ticks. A tick changes the output on the same edge that samples it. The bench drives each tick for one cycle between falling edges and reads the output at the falling edge that follows, so phase lengths come out as exact tick counts. An interrupt edge needs three rising edges to reach the output: two synchronizer stages and the timer flop. The bench checks that the output has not changed after two edges and has changed after three. For ignored lines it waits well past that latency before it reads the output.

// File: rtl/stc_pkg.sv
package stc_pkg;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_RUN  = 2'd1;
   localparam logic [ADDR_W-1:0] A_STOP = 2'd2;
   localparam logic [ADDR_W-1:0] A_MASK = 2'd3;

   typedef enum logic {
      PH_RUN  = 1'b0,
      PH_STOP = 1'b1
   } phase_e;
endpackage

// File: rtl/stc_regs.sv
module stc_regs
   import stc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W = 8,
   parameter int N_IRQ = 8,
   parameter int EN_BIT = 1,
   parameter logic [N_IRQ-1:0] RSVD_MASK = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              en,
   output logic [CNT_W-1:0]  run_cnt,
   output logic [CNT_W-1:0]  stop_cnt,
   output logic [N_IRQ-1:0]  mask
);
   logic              en_q;
   logic [CNT_W-1:0]  run_q, stop_q;
   logic [N_IRQ-1:0]  mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         run_q  <= '0;
         stop_q <= '0;
         mask_q <= '0;
      end else if (we) begin
         case (addr)
            A_CTRL: en_q   <= wdata[EN_BIT];
            A_RUN:  run_q  <= wdata[CNT_W-1:0];
            A_STOP: stop_q <= wdata[CNT_W-1:0];
            default: mask_q <= wdata[N_IRQ-1:0] & ~RSVD_MASK;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: rdata[EN_BIT] = en_q;
         A_RUN:  rdata[CNT_W-1:0] = run_q;
         A_STOP: rdata[CNT_W-1:0] = stop_q;
         default: rdata[N_IRQ-1:0] = mask_q;
      endcase
   end

   assign en       = en_q;
   assign run_cnt  = run_q;
   assign stop_cnt = stop_q;
   assign mask     = mask_q;
endmodule

// File: rtl/stc_brk_detect.sv
module stc_brk_detect #(
   parameter int N_IRQ = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [N_IRQ-1:0] RSVD_MASK = 8'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq,
   input  logic [N_IRQ-1:0] mask,
   output logic             brk
);
   logic [N_IRQ-1:0] line_s, line_prev, hit;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_s = irq;
      end else begin : g_sync
         logic [N_IRQ-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= irq;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign line_s = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= '0;
      else        line_prev <= line_s;
   end

   // rising edge of each enabled, non-reserved line
   assign hit = line_s & ~line_prev & mask & ~RSVD_MASK;
   assign brk = |hit;
endmodule

// File: rtl/stc_phase_timer.sv
module stc_phase_timer
   import stc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             brk,
   input  logic [CNT_W-1:0] run_cnt,
   input  logic [CNT_W-1:0] stop_cnt,
   output logic             stop_n,
   output logic             err
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             running_q, err_q;
   logic             load_run, load_stop;
   logic [CNT_W-1:0] run_eff, stop_eff;

   // an illegal zero count runs as one tick
   assign run_eff  = (run_cnt  == '0) ? ONE : run_cnt;
   assign stop_eff = (stop_cnt == '0) ? ONE : stop_cnt;

   always_comb begin
      load_run  = 1'b0;
      load_stop = 1'b0;
      if (en) begin
         if (!running_q || brk) begin
            load_run = 1'b1;
         end else if (tick && cnt_q <= ONE) begin
            if (phase_q == PH_RUN) load_stop = 1'b1;
            else                   load_run  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_RUN;
         cnt_q     <= '0;
         running_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         running_q <= en;
         if (!en) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
         end else if (load_run) begin
            phase_q <= PH_RUN;
            cnt_q   <= run_eff;
            if (run_cnt == '0) err_q <= 1'b1;
         end else if (load_stop) begin
            phase_q <= PH_STOP;
            cnt_q   <= stop_eff;
            if (stop_cnt == '0) err_q <= 1'b1;
         end else if (tick) begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign stop_n = (phase_q == PH_RUN);
   assign err    = err_q;
endmodule

// File: rtl/throttle_timer.sv
module throttle_timer
   import stc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W = 8,
   parameter int N_IRQ = 8,
   parameter int SYNC_STAGES = 2,
   parameter int EN_BIT = 1,
   parameter logic [N_IRQ-1:0] RSVD_MASK = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [N_IRQ-1:0]  irq,
   output logic              cpu_stop_n,
   output logic              cnt_err
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("throttle_timer: CNT_W must lie in 1..DATA_W");
      end
      if (N_IRQ < 1 || N_IRQ > DATA_W) begin : g_bad_irq
         $error("throttle_timer: N_IRQ must lie in 1..DATA_W");
      end
      if (EN_BIT < 0 || EN_BIT >= DATA_W) begin : g_bad_en
         $error("throttle_timer: EN_BIT outside data word");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("throttle_timer: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             en_w, brk_w;
   logic [CNT_W-1:0] run_w, stop_w;
   logic [N_IRQ-1:0] mask_w;

   stc_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .N_IRQ(N_IRQ),
      .EN_BIT(EN_BIT), .RSVD_MASK(RSVD_MASK)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .en(en_w),
      .run_cnt(run_w), .stop_cnt(stop_w), .mask(mask_w)
   );

   stc_brk_detect #(
      .N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES), .RSVD_MASK(RSVD_MASK)
   ) i_brk (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mask(mask_w), .brk(brk_w)
   );

   stc_phase_timer #(
      .CNT_W(CNT_W)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick), .brk(brk_w),
      .run_cnt(run_w), .stop_cnt(stop_w), .stop_n(cpu_stop_n), .err(cnt_err)
   );
endmodule

// File: rtl/stc_checker.sv
module stc_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic tick,
   input logic brk,
   input logic stop_n,
   input logic err
);
   // R3: disabled throttling keeps the clock running
   a_r3_idle_running: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> stop_n);

   // R10: error flag is sticky
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R6: an accepted break always leaves the clock running
   a_r6_break_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && en && $past(en)) |=> stop_n);

   // R4: the clock is stopped only on a tick
   a_r4_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_n) |-> $past(tick));

   // R5: the clock restarts only on a tick, a break or a disable
   a_r5_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_n) |-> ($past(tick) || $past(brk) || !$past(en)));
endmodule

bind throttle_timer stc_checker i_chk (
   .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick), .brk(brk_w),
   .stop_n(cpu_stop_n), .err(cnt_err)
);

// File: tb/test_throttle_timer.sv
module test_throttle_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = 2'd0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic [7:0] irq = 8'h00;
   logic       cpu_stop_n;
   logic       cnt_err;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   throttle_timer i_throttle_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq(irq), .cpu_stop_n(cpu_stop_n), .cnt_err(cnt_err)
   );

   // {run count, stop count}
   localparam logic [15:0] VEC [6] = '{
      16'h0101, 16'h0302, 16'h0205, 16'h0703, 16'h1009, 16'hFF02
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic give_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ticks until the output changes level
   task automatic measure(output int n);
      logic start;
      start = cpu_stop_n;
      n = 0;
      while (cpu_stop_n == start && n < 400) begin
         give_tick();
         n++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      irq = 8'h00; tick = 1'b0;
      idle(2); rst_n = 1'b1; idle(1);
   endtask

   task automatic enable();
      wr(2'd0, 8'h02);
      idle(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int n;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 stop_n", cpu_stop_n, 1);
      chk("R1 err", cnt_err, 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reg reset", d, 0);
      end

      // R2 readback, mask bit 2 reserved
      wr(2'd1, 8'hA5); rd(2'd1, d); chk("R2 run cnt", d, 8'hA5);
      wr(2'd2, 8'h3C); rd(2'd2, d); chk("R2 stop cnt", d, 8'h3C);
      wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 mask bit2", d, 8'hFB);
      wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 ctrl", d, 8'h02);
      wr(2'd0, 8'h00);

      // R3 disabled: ticks and edges do nothing
      wr(2'd1, 8'h01); wr(2'd2, 8'h01);
      idle(2);
      for (int i = 0; i < 5; i++) give_tick();
      irq = 8'h01; idle(4); irq = 8'h00;
      chk("R3 idle high", cpu_stop_n, 1);

      // R4 R5 vector walk
      wr(2'd3, 8'h00);
      foreach (VEC[v]) begin
         wr(2'd0, 8'h00);
         wr(2'd1, VEC[v][15:8]);
         wr(2'd2, VEC[v][7:0]);
         enable();
         measure(n); chk("R4 run phase", n, int'(VEC[v][15:8]));
         measure(n); chk("R5 stop phase", n, int'(VEC[v][7:0]));
         measure(n); chk("R4 run phase again", n, int'(VEC[v][15:8]));
      end

      // R3 disable while stopped
      wr(2'd0, 8'h00); wr(2'd1, 8'h01); wr(2'd2, 8'h20);
      enable(); give_tick();
      chk("R3 stopped before", cpu_stop_n, 0);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h00;
      @(negedge clk); cfg_we = 1'b0;
      @(negedge clk);
      chk("R3 disable releases", cpu_stop_n, 1);

      // R6 break while stopped, latency and full reload
      wr(2'd1, 8'h04); wr(2'd2, 8'h0A); wr(2'd3, 8'h01);
      enable();
      for (int i = 0; i < 4; i++) give_tick();
      for (int i = 0; i < 3; i++) give_tick();
      chk("R6 stopped", cpu_stop_n, 0);
      @(negedge clk); irq = 8'h01;
      @(negedge clk); @(negedge clk);
      chk("R6 not yet", cpu_stop_n, 0);
      @(negedge clk);
      chk("R6 released", cpu_stop_n, 1);
      irq = 8'h00;
      measure(n); chk("R6 full run phase", n, 4);

      // R7 break while running reloads
      wr(2'd0, 8'h00); wr(2'd1, 8'h05); wr(2'd2, 8'h09);
      enable();
      give_tick(); give_tick();
      irq = 8'h01; idle(4); irq = 8'h00; idle(2);
      chk("R7 still running", cpu_stop_n, 1);
      measure(n); chk("R7 reloaded run", n, 5);

      // R8 reserved line 2 and masked lines ignored
      wr(2'd0, 8'h00); wr(2'd1, 8'h02); wr(2'd2, 8'h14); wr(2'd3, 8'hFF);
      enable();
      give_tick(); give_tick();
      irq = 8'h04; idle(6); irq = 8'h00; idle(2);
      chk("R8 line2 ignored", cpu_stop_n, 0);
      wr(2'd3, 8'h01);
      irq = 8'h20; idle(6); irq = 8'h00; idle(2);
      chk("R8 masked line ignored", cpu_stop_n, 0);
      measure(n); chk("R8 stop phase intact", n, 20);

      // R9 level-held line breaks once
      wr(2'd0, 8'h00); wr(2'd1, 8'h02); wr(2'd2, 8'h04); wr(2'd3, 8'h01);
      enable();
      give_tick(); give_tick();
      irq = 8'h01; idle(4);
      chk("R9 first break", cpu_stop_n, 1);
      measure(n); chk("R9 run phase", n, 2);
      measure(n); chk("R9 stop not cut", n, 4);
      irq = 8'h00;

      // R10 zero counts
      do_reset();
      chk("R10 err clear", cnt_err, 0);
      enable();
      chk("R10 err set", cnt_err, 1);
      measure(n); chk("R10 zero run", n, 1);
      measure(n); chk("R10 zero stop", n, 1);
      wr(2'd1, 8'h03); wr(2'd2, 8'h03);
      measure(n); measure(n);
      chk("R10 err sticky", cnt_err, 1);
      do_reset();
      chk("R10 reset clears", cnt_err, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule